// File: doc/BRIEF.md
# I2C Register-Map Target

This block is an I2C target that gives a bus master byte access to a 64-location register space. Locations 0x00 to 0x07 belong to an external timekeeping counter. Locations 0x08 to 0x3F are 56 bytes of general-purpose RAM held inside the block. A fast system clock oversamples SCL and SDA. The block finds START and STOP conditions and recognises a single fixed 7-bit address. It drives the open-drain SDA line low through an output-enable for acknowledges and for the zero bits of read data.

The live time value enters on a 64-bit port. Byte k of that port is location k. Reads of the eight time locations never see this port directly. They see a snapshot bank, which is reloaded on START, on STOP and when the register pointer rolls over to 0x00. A multi-byte read of the time therefore returns one coherent sample while the counter keeps running. Writes to the time locations leave the block as a one-cycle strobe with an address and a data byte, so the counter can load them. A power-fail input silences the block completely.

Top module: `i2c_regmap_target`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 1101000. Bit 0 of that byte is the direction: 0 for write and 1 for read.
- R2: In a write transfer, the first byte after the address loads the 6-bit register pointer from bits 5:0. Each later byte is stored at the pointer, and the pointer then increments.
- R3: The pointer steps from 0x3F to 0x00, in both writes and reads.
- R4: Reads of locations 0x00 to 0x07 return the snapshot bank. Snapshot byte k holds bits 8k+7:8k of the live-time port as sampled at the most recent START, STOP or pointer rollover to 0x00.
- R5: A read transfer starts at the current pointer value, even when no pointer byte was written in the same transfer. It sends each byte MSB first and increments the pointer after every byte.
- R6: The block acknowledges the matching address byte and every byte it receives by driving SDA low for the whole high phase of the ninth SCL pulse. Outside an acknowledge or a read bit it leaves SDA released.
- R7: When the master returns a not-acknowledge after a read byte, the block releases SDA. It drives nothing more until the next START or STOP.
- R8: A written byte commits during the high phase of its acknowledge pulse. Bytes for 0x00 to 0x07 appear once on the time-write strobe with a 3-bit address. Bytes for 0x08 to 0x3F go into the RAM.
- R9: While the power-fail input is high, the block gives no acknowledge, drives no data and changes no register.
- R10: A repeated START returns the block to the address phase and keeps the pointer.
- R11: After a non-matching address, the block ignores every bus bit until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be many times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| pwr_fail_i | input | 1 | High while supply is failing; block stays silent |
| live_time_i | input | 64 | Running time bytes, byte k at bits 8k+7:8k |
| time_wr_en_o | output | 1 | One-cycle strobe for a write to a time location |
| time_wr_addr_o | output | 3 | Time location being written |
| time_wr_data_o | output | 8 | Byte being written to the time location |

## Verification
Every 7-bit address is swept with a follow-up byte. This separates correct address decoding from a target that acknowledges everything, and shows that a non-matching transfer stays ignored. A full walk of the RAM uses a computed byte pattern, written and then read back through a repeated START. This separates pointer loading, incrementing and MSB-first ordering from aliasing faults. The live-time port is changed right after a START and again across a pointer rollover from 0x3F. This tells a snapshot taken at the right moment apart from a live read or a missed rollover. Further transfers under power-fail, after a not-acknowledge, and to the time locations isolate the silencing, the release and the commit timing.

// File: rtl/i2c_regmap_pkg.sv
// Package: shared types and constants for the I2C register-map target.
// Assumes a byte-wide register space and the standard 9-clock byte frame.
package i2c_regmap_pkg;

    // Protocol engine states
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,   // bus free or after STOP
        ST_ADDR  = 3'd1,   // receiving the address byte
        ST_AACK  = 3'd2,   // acknowledging our address
        ST_WBYTE = 3'd3,   // receiving a write byte
        ST_WACK  = 3'd4,   // acknowledging a write byte, commit point
        ST_RBYTE = 3'd5,   // shifting out a read byte
        ST_RACK  = 3'd6,   // waiting for the master's acknowledge
        ST_IGN   = 3'd7    // ignoring the bus until START/STOP
    } tgt_state_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the system clock domain through two flops each,
// then compares them with a third registered copy to produce one-cycle
// pulses for SCL edges and for START / STOP conditions.
// Assumes the system clock oversamples SCL by a wide margin.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    // Synchronizer chains; idle bus level is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Previous-sample register for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    // Edge and bus-condition decode
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_evt = scl_s & scl_q & sda_q & ~sda_s;
        stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_regmap_store.sv
// Module: i2c_regmap_store
// Holds the general RAM and the time snapshot bank, and serves the read mux.
// Locations below N_TIME map to the snapshot on read and to the external
// time-write strobe on write; the rest map to RAM.
// Assumes N_TIME is a power of two and smaller than N_LOC.
module i2c_regmap_store #(
    parameter int N_LOC  = 64,
    parameter int N_TIME = 8,
    localparam int PTR_W = $clog2(N_LOC),
    localparam int TA_W  = $clog2(N_TIME),
    localparam int N_RAM = N_LOC - N_TIME
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_TIME*8-1:0]  live_time_i,
    input  logic                 snap_req,
    input  logic                 wr_en,
    input  logic [PTR_W-1:0]     wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [PTR_W-1:0]     rd_addr,
    output logic [7:0]           rd_data,
    output logic                 time_wr_en_o,
    output logic [TA_W-1:0]      time_wr_addr_o,
    output logic [7:0]           time_wr_data_o
);

    localparam logic [PTR_W-1:0] TIME_TOP = PTR_W'(N_TIME);

    logic [7:0]       ram  [N_RAM];
    logic [7:0]       snap [N_TIME];
    logic [PTR_W-1:0] wr_ram_idx;
    logic [PTR_W-1:0] rd_ram_idx;
    logic             wr_is_time;

    assign wr_is_time = (wr_addr < TIME_TOP);
    assign wr_ram_idx = wr_addr - TIME_TOP;
    assign rd_ram_idx = rd_addr - TIME_TOP;

    // Snapshot bank: one byte register per time location
    for (genvar k = 0; k < N_TIME; k++) begin : g_snap
        always_ff @(posedge clk) begin
            if (!rst_n)
                snap[k] <= '0;
            else if (snap_req)
                snap[k] <= live_time_i[k*8 +: 8];
        end
    end

    // General RAM write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_RAM; i++) ram[i] <= '0;
        end else if (wr_en && !wr_is_time) begin
            ram[wr_ram_idx] <= wr_data;
        end
    end

    // Read mux: time locations come from the snapshot, others from RAM
    always_comb begin
        if (rd_addr < TIME_TOP)
            rd_data = snap[rd_addr[TA_W-1:0]];
        else
            rd_data = ram[rd_ram_idx];
    end

    // Time-location writes leave the block as a strobe
    always_comb begin
        time_wr_en_o   = wr_en && wr_is_time;
        time_wr_addr_o = wr_addr[TA_W-1:0];
        time_wr_data_o = wr_data;
    end

    // R4: a snapshot request captures the live time on the next edge
    p_snap_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (snap[0] == $past(live_time_i[7:0])));

endmodule

// File: rtl/i2c_target_engine.sv
// Module: i2c_target_engine
// Bit and byte protocol engine: address match, acknowledge generation,
// pointer handling, write commit and read shifting.
// Assumes clean one-cycle event pulses from i2c_line_sync and no clock
// stretching.
module i2c_target_engine
    import i2c_regmap_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         N_LOC    = 64,
    localparam int        PTR_W    = $clog2(N_LOC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_fail,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_evt,
    input  logic             stop_evt,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_en,
    output logic [7:0]       wr_data,
    output logic             snap_req,
    output logic             sda_oe
);

    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N_LOC - 1);

    tgt_state_t state;
    logic [2:0] bit_cnt;
    logic       full;
    logic [7:0] shreg;
    logic [7:0] tx;
    logic       need_ptr;
    logic       ptr_step;

    // Commit and pointer-step decode
    always_comb begin
        wr_en    = !pwr_fail && (state == ST_WACK) && scl_rise && !need_ptr;
        ptr_step = wr_en ||
                   (!pwr_fail && (state == ST_RBYTE) && scl_fall && (bit_cnt == 3'd7));
        snap_req = start_evt || stop_evt || (ptr_step && (ptr == PTR_LAST));
        wr_data  = shreg;
    end

    // Protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            full     <= 1'b0;
            shreg    <= '0;
            tx       <= '0;
            need_ptr <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
        end else if (pwr_fail) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (start_evt) begin
            state   <= ST_ADDR;
            bit_cnt <= '0;
            full    <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (stop_evt) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            if (ptr_step) ptr <= ptr + 1'b1;
            unique case (state)
                ST_ADDR, ST_WBYTE: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                        full    <= (bit_cnt == 3'd7);
                    end else if (scl_fall && full) begin
                        full <= 1'b0;
                        if (state == ST_WBYTE) begin
                            sda_oe <= 1'b1;
                            state  <= ST_WACK;
                        end else if (shreg[7:1] == DEV_ADDR) begin
                            sda_oe   <= 1'b1;
                            need_ptr <= ~shreg[0];
                            state    <= ST_AACK;
                        end else begin
                            state <= ST_IGN;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (shreg[0]) begin
                            tx     <= rd_data;
                            sda_oe <= ~rd_data[7];
                            state  <= ST_RBYTE;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WBYTE;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_rise && need_ptr) begin
                        ptr      <= shreg[PTR_W-1:0];
                        need_ptr <= 1'b0;
                    end else if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_WBYTE;
                    end
                end
                ST_RBYTE: begin
                    if (scl_fall) begin
                        if (bit_cnt == 3'd7) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_RACK;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                            tx      <= {tx[6:0], 1'b0};
                            sda_oe  <= ~tx[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise && sda_s) begin
                        state <= ST_IGN;
                    end else if (scl_fall) begin
                        tx     <= rd_data;
                        sda_oe <= ~rd_data[7];
                        state  <= ST_RBYTE;
                    end
                end
                default: ;
            endcase
        end
    end

    // R9: power-fail silences the SDA driver on the next edge
    p_pf_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !sda_oe);

    // R7: a STOP always leaves SDA released
    p_stop_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);

    // R8: a commit happens only while acknowledging with SCL high
    p_commit_in_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (sda_oe && scl_s));

    // R3: stepping past the last location lands on location zero
    p_ptr_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_step && (ptr == PTR_LAST) && !start_evt && !stop_evt) |=> (ptr == '0));

    // R11: an ignored transfer never drives the bus
    p_ign_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGN) |-> !sda_oe);

endmodule

// File: rtl/i2c_regmap_target.sv
// Module: i2c_regmap_target (top)
// I2C target with a 64-location register space: eight snapshot-read time
// locations written through an external strobe, and general RAM above.
// Assumes SCL/SDA inputs carry the wired-AND bus levels.
module i2c_regmap_target #(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         N_LOC    = 64,
    parameter int         N_TIME   = 8,
    localparam int        PTR_W    = $clog2(N_LOC),
    localparam int        TA_W     = $clog2(N_TIME)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    input  logic                pwr_fail_i,
    input  logic [N_TIME*8-1:0] live_time_i,
    output logic                time_wr_en_o,
    output logic [TA_W-1:0]     time_wr_addr_o,
    output logic [7:0]          time_wr_data_o
);

    logic             scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic [7:0]       rd_data;
    logic [PTR_W-1:0] ptr;
    logic             wr_en;
    logic [7:0]       wr_data;
    logic             snap_req;

    i2c_line_sync #(.SYNC_STAGES(2)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_target_engine #(.DEV_ADDR(DEV_ADDR), .N_LOC(N_LOC)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_fail  (pwr_fail_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rd_data   (rd_data),
        .ptr       (ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .snap_req  (snap_req),
        .sda_oe    (sda_oe_o)
    );

    i2c_regmap_store #(.N_LOC(N_LOC), .N_TIME(N_TIME)) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .live_time_i    (live_time_i),
        .snap_req       (snap_req),
        .wr_en          (wr_en),
        .wr_addr        (ptr),
        .wr_data        (wr_data),
        .rd_addr        (ptr),
        .rd_data        (rd_data),
        .time_wr_en_o   (time_wr_en_o),
        .time_wr_addr_o (time_wr_addr_o),
        .time_wr_data_o (time_wr_data_o)
    );

endmodule

// File: tb/i2c_regmap_target_bench.sv
// Bench: drives an I2C master model against the target and checks results
// computed from the requirements.
module i2c_regmap_target_bench;

    localparam int H = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        pwr_fail = 1'b0;
    logic [63:0] live = '0;
    logic        sda_oe;
    logic        tw_en;
    logic [2:0]  tw_addr;
    logic [7:0]  tw_data;
    wire         sda_line = sda_m & ~sda_oe;

    int n_run = 0;
    int n_fail = 0;

    logic [2:0] lg_addr [16];
    logic [7:0] lg_data [16];
    logic       lg_scl  [16];
    int         lg_n = 0;

    always #2 clk = ~clk;

    i2c_regmap_target u_i2c_regmap_target (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (scl_m),
        .sda_i          (sda_line),
        .sda_oe_o       (sda_oe),
        .pwr_fail_i     (pwr_fail),
        .live_time_i    (live),
        .time_wr_en_o   (tw_en),
        .time_wr_addr_o (tw_addr),
        .time_wr_data_o (tw_data)
    );

    // Log time-location write strobes with the SCL level at that moment
    always @(posedge clk) begin
        if (tw_en && lg_n < 16) begin
            lg_addr[lg_n] = tw_addr;
            lg_data[lg_n] = tw_data;
            lg_scl[lg_n]  = scl_m;
            lg_n = lg_n + 1;
        end
    end

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (H) @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b0; hp();
        scl_m = 1'b0; settle();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b1; hp();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; hp();
        scl_m = 1'b1; hp();
        scl_m = 1'b0; settle();
    endtask

    // Send a byte MSB first, then sample the acknowledge in mid-high phase
    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; hp();
        scl_m = 1'b1;
        repeat (H/2) @(negedge clk);
        ack = ~sda_line;
        repeat (H - H/2) @(negedge clk);
        scl_m = 1'b0; settle();
    endtask

    // Receive a byte MSB first, then return ack (1) or not-ack (0)
    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hp();
            scl_m = 1'b1;
            repeat (H/2) @(negedge clk);
            d[i] = sda_line;
            repeat (H - H/2) @(negedge clk);
            scl_m = 1'b0; settle();
        end
        send_bit(~give_ack);
    endtask

    // Watchdog: an expired run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        logic [63:0] l1, l2;
        int         base;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sda_oe == 1'b0, "R6 reset released", sda_oe, 0);

        // R1 / R11: sweep every address; follow-up byte acked only on a match
        for (int a = 0; a < 128; a++) begin
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            chk(ack == (a == 7'h68), "R1 address match", ack, (a == 7'h68));
            send_byte(8'hD0, ack);
            chk(ack == (a == 7'h68), "R11 ignore after mismatch", ack, (a == 7'h68));
            bus_stop();
        end

        // R2 / R6: write the whole RAM with a computed pattern
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h08, ack);
        chk(ack == 1'b1, "R6 pointer byte ack", ack, 1);
        for (int i = 0; i < 56; i++) begin
            send_byte(pat(i), ack);
            chk(ack == 1'b1, "R6 data byte ack", ack, 1);
        end
        bus_stop();

        // R2 / R5 / R10: set pointer, repeated START, read all RAM back
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h08, ack);
        bus_start();
        send_byte(8'hD1, ack);
        chk(ack == 1'b1, "R10 read address after repeated start", ack, 1);
        for (int i = 0; i < 56; i++) begin
            recv_byte(i != 55, d);
            chk(d == pat(i), "R5 R2 RAM readback", d, pat(i));
        end
        bus_stop();

        // R8: time-location writes appear as strobes during the ack high phase
        lg_n = 0;
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h03, ack);
        send_byte(8'hA5, ack);
        send_byte(8'h5A, ack);
        bus_stop();
        chk(lg_n == 2, "R8 strobe count", lg_n, 2);
        chk(lg_addr[0] == 3'd3 && lg_data[0] == 8'hA5, "R8 first strobe",
            {lg_addr[0], lg_data[0]}, {3'd3, 8'hA5});
        chk(lg_addr[1] == 3'd4 && lg_data[1] == 8'h5A, "R8 second strobe",
            {lg_addr[1], lg_data[1]}, {3'd4, 8'h5A});
        chk(lg_scl[0] == 1'b1 && lg_scl[1] == 1'b1, "R8 commit in ack high",
            {lg_scl[0], lg_scl[1]}, 2'b11);

        // R3: write wrap from 0x3F to 0x00
        lg_n = 0;
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h3F, ack);
        send_byte(8'h77, ack);
        send_byte(8'hC3, ack);
        bus_stop();
        chk(lg_n == 1 && lg_addr[0] == 3'd0 && lg_data[0] == 8'hC3,
            "R3 write wraps to 0x00", {lg_addr[0], lg_data[0]}, {3'd0, 8'hC3});

        // R3 / R4: read wrap; rollover reloads the snapshot
        l1 = 64'h1122334455667788;
        l2 = 64'h99AABBCCDDEEF001;
        live = l1;
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h3F, ack);
        bus_start();
        live = l2;
        send_byte(8'hD1, ack);
        recv_byte(1'b1, d);
        chk(d == 8'h77, "R3 read at 0x3F", d, 8'h77);
        recv_byte(1'b1, d);
        chk(d == l2[7:0], "R4 rollover snapshot byte0", d, l2[7:0]);
        recv_byte(1'b0, d);
        chk(d == l2[15:8], "R4 rollover snapshot byte1", d, l2[15:8]);
        bus_stop();

        // R4: START snapshot stays coherent while live time moves
        live = l1;
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h00, ack);
        bus_start();
        live = l2;
        send_byte(8'hD1, ack);
        for (int k = 0; k < 8; k++) begin
            recv_byte(k != 7, d);
            chk(d == l1[k*8 +: 8], "R4 start snapshot", d, l1[k*8 +: 8]);
        end

        // R7: after not-ack the target stays off the bus
        repeat (H) begin
            @(negedge clk);
            chk(sda_oe == 1'b0, "R7 released after nack", sda_oe, 0);
        end
        for (int i = 0; i < 9; i++) begin
            sda_m = 1'b1; hp();
            scl_m = 1'b1; hp();
            chk(sda_line == 1'b1, "R7 no drive after nack", sda_line, 1);
            scl_m = 1'b0; settle();
        end
        bus_stop();

        // R5: read without pointer write continues at 0x08
        bus_start();
        send_byte(8'hD1, ack);
        recv_byte(1'b1, d);
        chk(d == pat(0), "R5 continue at pointer", d, pat(0));
        recv_byte(1'b0, d);
        chk(d == pat(1), "R5 pointer increments", d, pat(1));
        bus_stop();

        // R9: power-fail blocks acknowledge and writes
        pwr_fail = 1'b1;
        lg_n = 0;
        bus_start();
        send_byte(8'hD0, ack);
        chk(ack == 1'b0, "R9 no ack under power-fail", ack, 0);
        send_byte(8'h20, ack);
        send_byte(8'h99, ack);
        chk(ack == 1'b0, "R9 no data ack", ack, 0);
        bus_stop();
        pwr_fail = 1'b0;
        repeat (4) @(negedge clk);
        base = 8'h20 - 8;
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h20, ack);
        bus_start();
        send_byte(8'hD1, ack);
        recv_byte(1'b0, d);
        chk(d == pat(base), "R9 RAM unchanged", d, pat(base));
        bus_stop();
        chk(lg_n == 0, "R9 no time strobe", lg_n, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule